// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block decides when a clock generator may sleep and when it may wake. A low-power request arrives on an active-low pin with no timing relation to the core clock. The block passes that request through a chain of flops clocked by the core clock. It then closes every output clock gate: the stoppable CPU gates, the stoppable PCI gates, the free-running PCI gate and the reference gate. One cycle later, once the gates are known to be closed, it drops the VCO enable and the oscillator enable. Because the gates are already shut when the sources stop, no truncated pulse can reach an output.

On release, the VCO and oscillator enables come back first. The gates stay closed while the block counts strobes from an always-on slow timebase. The gates reopen only when a programmable number of strobes has been seen, which gives the oscillator and PLL time to settle. While the block is asleep or waking, the individual CPU-stop and PCI-stop controls have no effect. Leaving reset is handled like a wake-up: the sources are enabled and the gates wait for the same settling count.

The gate outputs are registered enables for downstream clock-gating cells. Simulation keeps the core clock running. In silicon it would stop along with the VCO, and the slow timebase would carry the settling count.

Top module: `pwrdn_seq`

## Requirements
- R1: `pd_req_n` passes through SYNC_STAGES flops, 2 by default. With the default, a level change of `pd_req_n` first affects the outputs at the third rising edge of `clk` after the change.
- R2: When a request is asserted (`pd_req_n` low) in the running state, all gate outputs go to 0 on the same edge. The gate outputs are every bit of `cpu_gate` and `pci_gate`, plus `pcif_gate` and `ref_gate`. With default parameters this is the third rising edge after the request.
- R3: `vco_en` and `osc_en` fall together, exactly one edge after the gates closed. They are never 0 while any gate output is 1.
- R4: While `osc_en` is 0, every gate output stays 0 whatever `cpu_stop_n`, `pci_stop_n` and `tick_slow` do.
- R5: After `pd_req_n` returns high, `vco_en` and `osc_en` return to 1 on the third rising edge, while all gates remain 0.
- R6: After the enables return, the block counts each rising edge at which `tick_slow` is 1. The gates open on the edge that samples the STAB_TICKS-th such strobe, and not before.
- R7: If the request is asserted again while the block waits for the count, `vco_en` and `osc_en` fall on the third rising edge and the gates stay closed. A later release starts the count again from zero.
- R8: While running, each `cpu_gate` bit equals `cpu_stop_n` and each `pci_gate` bit equals `pci_stop_n` as sampled at the previous rising edge (1 = clock passes). `pcif_gate` and `ref_gate` are 1.
- R9: While `rst_n` is low, `vco_en` and `osc_en` are 1 and all gates are 0. After reset the gates open only after STAB_TICKS strobes, as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| tick_slow | input | 1 | One-cycle strobe from the always-on slow timebase |
| cpu_stop_n | input | 1 | CPU clock run control, 1 = run |
| pci_stop_n | input | 1 | Stoppable PCI clock run control, 1 = run |
| cpu_gate | output | N_CPU | CPU clock gate enables |
| pci_gate | output | N_PCI | Stoppable PCI clock gate enables |
| pcif_gate | output | 1 | Free-running PCI clock gate enable |
| ref_gate | output | 1 | Reference clock gate enable |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
The bench builds the block with N_CPU=2, N_PCI=5, a two-flop synchronizer and STAB_TICKS=5. This short settling count lets every count boundary be reached in a few dozen cycles: one strobe short of expiry, expiry itself, and a restart after a mid-count request. Strobes are applied both spaced apart and on back-to-back cycles. The two-flop setting makes the three-edge entry and exit latencies exact and easy to observe. With nine gate bits, a bit-level error in any gate group shows up at the ports.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [1:0] {
      PD_RUN   = 2'd0,
      PD_GATE  = 2'd1,
      PD_SLEEP = 2'd2,
      PD_WAKE  = 2'd3
   } pd_state_e;

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
   parameter int STAB_TICKS = 5,
   localparam int CW = $clog2(STAB_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic counting,
   input  logic tick,
   output logic expire
);

   localparam logic [CW-1:0] LAST = CW'(STAB_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!counting)       cnt_q <= '0;
      else if (tick && !expire) cnt_q <= cnt_q + 1'b1;
   end

   assign expire = counting && tick && (cnt_q == LAST);

   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST)
      else $error("settling counter beyond limit");

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
   import pwrdn_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_act,
   input  logic expire,
   output logic open_nxt,
   output logic counting,
   output logic osc_q
);

   pd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PD_RUN:   if (req_act) state_d = PD_GATE;
         PD_GATE:  state_d = PD_SLEEP;
         PD_SLEEP: if (!req_act) state_d = PD_WAKE;
         PD_WAKE: begin
            if (req_act)     state_d = PD_SLEEP;
            else if (expire) state_d = PD_RUN;
         end
         default:  state_d = PD_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PD_WAKE;
         osc_q   <= 1'b1;
      end else begin
         state_q <= state_d;
         osc_q   <= (state_d != PD_SLEEP);
      end
   end

   assign open_nxt = (state_d == PD_RUN);
   assign counting = (state_q == PD_WAKE);

endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_i,
   input  logic         run_n_i,
   output logic [W-1:0] gate_q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate_q[i] <= 1'b0;
         else        gate_q[i] <= open_i & run_n_i;
      end
   end

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
   parameter int N_CPU       = 2,
   parameter int N_PCI       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int STAB_TICKS  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_req_n,
   input  logic             tick_slow,
   input  logic             cpu_stop_n,
   input  logic             pci_stop_n,
   output logic [N_CPU-1:0] cpu_gate,
   output logic [N_PCI-1:0] pci_gate,
   output logic             pcif_gate,
   output logic             ref_gate,
   output logic             vco_en,
   output logic             osc_en
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STAB_TICKS < 1) begin : g_bad_stab
      $error("STAB_TICKS must be at least 1");
   end
   if (N_CPU < 1 || N_PCI < 1) begin : g_bad_width
      $error("gate widths must be at least 1");
   end

   logic req_n_s, open_nxt, counting, expire, osc_q;

   pd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(pd_req_n), .dout(req_n_s));

   pd_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .req_act(!req_n_s), .expire(expire),
      .open_nxt(open_nxt), .counting(counting), .osc_q(osc_q));

   stab_timer #(.STAB_TICKS(STAB_TICKS)) i_timer (
      .clk(clk), .rst_n(rst_n), .counting(counting), .tick(tick_slow),
      .expire(expire));

   gate_bank #(.W(N_CPU)) i_cpu_gates (
      .clk(clk), .rst_n(rst_n), .open_i(open_nxt), .run_n_i(cpu_stop_n),
      .gate_q(cpu_gate));

   gate_bank #(.W(N_PCI)) i_pci_gates (
      .clk(clk), .rst_n(rst_n), .open_i(open_nxt), .run_n_i(pci_stop_n),
      .gate_q(pci_gate));

   gate_bank #(.W(1)) i_pcif_gate (
      .clk(clk), .rst_n(rst_n), .open_i(open_nxt), .run_n_i(1'b1),
      .gate_q(pcif_gate));

   gate_bank #(.W(1)) i_ref_gate (
      .clk(clk), .rst_n(rst_n), .open_i(open_nxt), .run_n_i(1'b1),
      .gate_q(ref_gate));

   assign vco_en = osc_q;
   assign osc_en = osc_q;

   logic gates_closed;
   assign gates_closed = (cpu_gate == '0) && (pci_gate == '0) && !pcif_gate && !ref_gate;

   // R2: the free-running gate never closes alone
   a_r2_close_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pcif_gate) |-> gates_closed)
      else $error("gates did not close together");

   // R3: sources stop only after gates were closed for a cycle
   a_r3_osc_after_gates: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en) |-> $past(gates_closed))
      else $error("oscillator stopped with a gate open");

   // R4: nothing opens while the sources are off
   a_r4_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> gates_closed)
      else $error("gate open while asleep");

   // R6: gates reopen only with sources already running
   a_r6_open_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcif_gate) |-> (osc_en && $past(osc_en)))
      else $error("gate opened without settled sources");

endmodule

// File: tb/test_pwrdn_seq.sv
module test_pwrdn_seq;

   localparam int NCPU = 2;
   localparam int NPCI = 5;
   localparam int STAB = 5;
   localparam int GW   = NCPU + NPCI + 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, pd_req_n, tick_slow, cpu_stop_n, pci_stop_n;
   logic [NCPU-1:0] cpu_gate;
   logic [NPCI-1:0] pci_gate;
   logic pcif_gate, ref_gate, vco_en, osc_en;

   int total = 0;
   int failed = 0;

   pwrdn_seq #(.N_CPU(NCPU), .N_PCI(NPCI), .SYNC_STAGES(2), .STAB_TICKS(STAB))
   i_pwrdn_seq (
      .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .tick_slow(tick_slow),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
      .cpu_gate(cpu_gate), .pci_gate(pci_gate), .pcif_gate(pcif_gate),
      .ref_gate(ref_gate), .vco_en(vco_en), .osc_en(osc_en));

   function automatic logic [GW-1:0] exp_gates(bit run, bit cs, bit ps);
      return run ? {{NCPU{cs}}, {NPCI{ps}}, 2'b11} : '0;
   endfunction

   function automatic logic [GW-1:0] act_gates();
      return {cpu_gate, pci_gate, pcif_gate, ref_gate};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spaced_ticks(int n);
      repeat (n) begin
         tick_slow = 1'b1;
         @(negedge clk);
         tick_slow = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      failed++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      bit cs, ps;
      void'($urandom(32'd1234));
      rst_n = 1'b0; pd_req_n = 1'b1; tick_slow = 1'b0;
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      wait_n(3);
      chk("R9 osc in reset", {vco_en, osc_en}, 2'b11);
      chk("R9 gates in reset", act_gates(), exp_gates(0, 1, 1));
      rst_n = 1'b1;
      wait_n(2);
      chk("R9 gates closed after reset", act_gates(), exp_gates(0, 1, 1));
      spaced_ticks(STAB - 1);
      chk("R9 one strobe short", act_gates(), exp_gates(0, 1, 1));
      tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
      chk("R9 gates open at count", act_gates(), exp_gates(1, 1, 1));

      // R8: running, random stop controls and ignored strobes
      for (int i = 0; i < 40; i++) begin
         cs = 1'($urandom % 2);
         ps = 1'($urandom % 2);
         cpu_stop_n = cs; pci_stop_n = ps; tick_slow = 1'($urandom % 2);
         @(negedge clk);
         chk("R8 stop follow", act_gates(), exp_gates(1, cs, ps));
      end
      tick_slow = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: entry
      pd_req_n = 1'b0;
      @(negedge clk);
      chk("R1 still open edge1", act_gates(), exp_gates(1, 1, 1));
      @(negedge clk);
      chk("R1 still open edge2", act_gates(), exp_gates(1, 1, 1));
      @(negedge clk);
      chk("R2 gates closed edge3", act_gates(), exp_gates(0, 1, 1));
      chk("R3 osc kept one cycle", {vco_en, osc_en}, 2'b11);
      @(negedge clk);
      chk("R3 osc off edge4", {vco_en, osc_en}, 2'b00);

      // R4: stops and strobes ignored asleep
      for (int i = 0; i < 12; i++) begin
         cpu_stop_n = 1'($urandom % 2);
         pci_stop_n = 1'($urandom % 2);
         tick_slow = 1'($urandom % 2);
         @(negedge clk);
         chk("R4 gates stay closed", act_gates(), exp_gates(0, 1, 1));
         chk("R4 osc stays off", {vco_en, osc_en}, 2'b00);
      end
      tick_slow = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;

      // R5 R6: wake with spaced strobes
      pd_req_n = 1'b1;
      wait_n(2);
      chk("R5 osc off edge2", {vco_en, osc_en}, 2'b00);
      @(negedge clk);
      chk("R5 osc on edge3", {vco_en, osc_en}, 2'b11);
      chk("R5 gates closed", act_gates(), exp_gates(0, 1, 1));
      spaced_ticks(STAB - 1);
      chk("R6 one strobe short", act_gates(), exp_gates(0, 1, 1));
      tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
      chk("R6 gates open", act_gates(), exp_gates(1, 1, 1));

      // R7: request during settling
      pd_req_n = 1'b0;
      wait_n(4);
      chk("R7 asleep again", {vco_en, osc_en}, 2'b00);
      pd_req_n = 1'b1;
      wait_n(3);
      chk("R7 woke", {vco_en, osc_en}, 2'b11);
      spaced_ticks(2);
      pd_req_n = 1'b0;
      wait_n(2);
      chk("R7 osc on edge2", {vco_en, osc_en}, 2'b11);
      @(negedge clk);
      chk("R7 osc off edge3", {vco_en, osc_en}, 2'b00);
      chk("R7 gates closed", act_gates(), exp_gates(0, 1, 1));
      wait_n(2);
      pd_req_n = 1'b1;
      wait_n(3);
      chk("R7 woke again", {vco_en, osc_en}, 2'b11);
      tick_slow = 1'b1;
      wait_n(STAB - 1);
      tick_slow = 1'b0;
      chk("R7 count restarted", act_gates(), exp_gates(0, 1, 1));
      tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
      chk("R7 R6 open after back-to-back strobes", act_gates(), exp_gates(1, 1, 1));

      summary();
   end

endmodule